// File: doc/BRIEF.md
# Multicycle 8-bit Accumulator Processor

This block is a small processor in which code and data sit in one shared byte-wide memory. It has an 8-bit accumulator and a 16-bit program counter, and it reaches the outside world only through a single memory port: a 16-bit address, a read-data byte, a write-data byte and a write strobe. The memory behind the port is outside the block. It returns the byte at the address presented in one cycle on the read bus in the next cycle, and it commits a write at the clock edge where the strobe is high.

Every instruction is an opcode byte. Each opcode other than the stop code is followed by a two-byte absolute operand address, high byte first. The core walks through a fixed nine-step sequence, one step per clock. The steps are: opcode fetch, decode, high operand byte address, high byte capture, low operand byte address, low byte capture, execute, result write, and program counter update. Any opcode byte that is not one of the six defined one-hot codes is treated as the stop code. This includes the zero byte of blank memory. When the core decodes a stop, it keeps refetching the same byte for ever and raises a status output that stays high until reset.

Top module: `accum_core`

## Requirements
- R1: While reset is low, the address bus is 0x0000, the write strobe is low and the halted output is low. After reset the first opcode is fetched from address 0x0000 and the accumulator holds 0x00.
- R2: Opcode 0x01 copies into the accumulator the byte at the operand address. The defined codes are 0x01 load, 0x02 store, 0x04 add, 0x08 subtract, 0x10 jump and 0x20 jump-if-zero, and 0x00 is stop.
- R3: The operand address is the byte after the opcode, taken as bits 15:8, followed by the byte after that, taken as bits 7:0.
- R4: Opcode 0x04 adds the byte at the operand address to the accumulator modulo 256, so 0xFF plus 0x01 gives 0x00.
- R5: Opcode 0x08 subtracts the byte at the operand address from the accumulator modulo 256, so 0x00 minus 0x01 gives 0xFF.
- R6: Opcode 0x02 raises the write strobe for exactly one cycle, with the operand address on the address bus and the accumulator on the write-data bus. No other opcode writes.
- R7: Opcode 0x10 continues execution at the operand address.
- R8: Opcode 0x20 continues at the operand address when the accumulator is 0x00. Otherwise it continues at the opcode address plus 3.
- R9: Opcode 0x00 sets the halted output within two clocks of the start of its fetch. After that, halted stays high, the address bus stays on the stop opcode's address, and no write happens until reset.
- R10: Any opcode byte other than the seven listed in R2 behaves exactly like 0x00. Examples are 0x03, 0x0C, 0x40 and 0x80.
- R11: Each non-stop instruction takes exactly nine clocks, and the program counter changes only in the last of them.
- R12: Program counter and operand-byte addresses wrap modulo 65536, so an instruction ending at 0xFFFF is followed by a fetch from 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| memAddr | output | 16 | Shared memory address for both code and data |
| memRdata | input | 8 | Byte for the address presented one cycle earlier |
| memWdata | output | 8 | Byte to be written, the accumulator |
| memWe | output | 1 | Write strobe, one cycle per store |
| halted | output | 1 | High once a stop or undefined opcode is decoded |

## Verification
Each program stores its result to a known address. The check then reads the modelled memory and counts the clocks from reset release to the halted edge. These clock counts separate the nine-step sequence from an off-by-one sequencer. Arithmetic is tried with values that cross both wrap points, where a carry or borrow leaking into the result would show. Jumps are placed so that a jump that is not taken, or a conditional jump taken the wrong way, would leave a different marker byte in memory and a different final address. Undefined opcodes with one bit set above the defined range, two bits set, and the top bit set are each checked to halt in place. A program that wraps through 0xFFFF shows whether the fetch lands on 0x0000 rather than on a widened address.

// File: rtl/accum_core_pkg.sv
package accum_core_pkg;

  // Steps of one instruction, one per clock
  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_ADDR_HI, S_READ_HI, S_ADDR_LO,
    S_READ_LO, S_EXEC, S_WRITE, S_ADVANCE
  } stepT;

  typedef enum logic [1:0] {ADR_PC, ADR_PC1, ADR_PC2, ADR_MAR} adrSelT;
  typedef enum logic [1:0] {ALU_PASS, ALU_ADD, ALU_SUB} aluOpT;

  // Bit positions inside the one-hot opcode
  localparam int BIT_LOAD  = 0;
  localparam int BIT_STORE = 1;
  localparam int BIT_ADD   = 2;
  localparam int BIT_SUB   = 3;
  localparam int BIT_JMP   = 4;
  localparam int BIT_JZ    = 5;
  localparam int OP_BITS   = 6;
  localparam int OPERAND_BYTES = 2;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    adrSelT adrSel;
    logic   grabHi;
    logic   grabAddr;
    logic   accWrite;
    aluOpT  aluOp;
    logic   memWrite;
    logic   pcAdvance;
    logic   pcJump;
  } ctlT;

endpackage

// File: rtl/accum_core_ctrl.sv
module accum_core_ctrl
  import accum_core_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              accZero,
  output ctlT               ctl,
  output logic              halted
);

  stepT               step, stepNext;
  logic [OP_BITS-1:0] opHot;
  logic [OP_BITS-1:0] decHot;
  logic               validOp;
  logic               haltQ;

  // One-hot decode: exactly one defined bit set and nothing above it
  always_comb begin
    validOp = (memRdata[DATA_W-1:OP_BITS] == '0) && $onehot(memRdata[OP_BITS-1:0]);
    decHot  = validOp ? memRdata[OP_BITS-1:0] : '0;
  end

  always_comb begin
    stepNext = step;
    unique case (step)
      S_FETCH:   stepNext = S_DECODE;
      S_DECODE:  stepNext = (decHot == '0) ? S_FETCH : S_ADDR_HI;
      S_ADDR_HI: stepNext = S_READ_HI;
      S_READ_HI: stepNext = S_ADDR_LO;
      S_ADDR_LO: stepNext = S_READ_LO;
      S_READ_LO: stepNext = S_EXEC;
      S_EXEC:    stepNext = S_WRITE;
      S_WRITE:   stepNext = S_ADVANCE;
      S_ADVANCE: stepNext = S_FETCH;
      default:   stepNext = S_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step  <= S_FETCH;
      opHot <= '0;
      haltQ <= 1'b0;
    end else begin
      step <= stepNext;
      if (step == S_DECODE) begin
        opHot <= decHot;
        haltQ <= haltQ | (decHot == '0);
      end
    end
  end

  always_comb begin
    ctl = '0;
    unique case (step)
      S_ADDR_HI, S_READ_HI: ctl.adrSel = ADR_PC1;
      S_ADDR_LO, S_READ_LO: ctl.adrSel = ADR_PC2;
      S_EXEC, S_WRITE:      ctl.adrSel = ADR_MAR;
      default:              ctl.adrSel = ADR_PC;
    endcase
    ctl.grabHi    = (step == S_READ_HI);
    ctl.grabAddr  = (step == S_READ_LO);
    ctl.accWrite  = (step == S_WRITE) &&
                    (opHot[BIT_LOAD] | opHot[BIT_ADD] | opHot[BIT_SUB]);
    ctl.aluOp     = opHot[BIT_ADD] ? ALU_ADD : (opHot[BIT_SUB] ? ALU_SUB : ALU_PASS);
    ctl.memWrite  = (step == S_WRITE) && opHot[BIT_STORE];
    ctl.pcAdvance = (step == S_ADVANCE);
    ctl.pcJump    = (step == S_ADVANCE) &&
                    (opHot[BIT_JMP] | (opHot[BIT_JZ] & accZero));
  end

  assign halted = haltQ;

  // Once stopped, only reset leaves the halted state
  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  // A stopped core never writes memory
  assert_no_write_halted_R9: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !ctl.memWrite);

endmodule

// File: rtl/accum_core_dp.sv
module accum_core_dp
  import accum_core_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlT                 ctl,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [2*DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic                memWe,
  output logic                accZero
);

  localparam int ADDR_W = OPERAND_BYTES * DATA_W;
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(OPERAND_BYTES + 1);

  logic [ADDR_W-1:0] pcQ, marQ;
  logic [DATA_W-1:0] accQ, hiQ, aluOut;

  always_comb begin
    unique case (ctl.adrSel)
      ADR_PC1: memAddr = pcQ + ADDR_W'(1);
      ADR_PC2: memAddr = pcQ + ADDR_W'(2);
      ADR_MAR: memAddr = marQ;
      default: memAddr = pcQ;
    endcase
  end

  always_comb begin
    unique case (ctl.aluOp)
      ALU_ADD: aluOut = accQ + memRdata;
      ALU_SUB: aluOut = accQ - memRdata;
      default: aluOut = memRdata;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ  <= '0;
      marQ <= '0;
      accQ <= '0;
      hiQ  <= '0;
    end else begin
      if (ctl.grabHi)   hiQ  <= memRdata;
      if (ctl.grabAddr) marQ <= {hiQ, memRdata};
      if (ctl.accWrite) accQ <= aluOut;
      if (ctl.pcAdvance) pcQ <= ctl.pcJump ? marQ : pcQ + PC_STEP;
    end
  end

  assign memWdata = accQ;
  assign memWe    = ctl.memWrite;
  assign accZero  = (accQ == '0);

  // PC moves only in the final step of an instruction
  assert_pc_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.pcAdvance |=> $stable(pcQ));

endmodule

// File: rtl/accum_core.sv
module accum_core
  import accum_core_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  output logic [2*DATA_W-1:0] memAddr,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [DATA_W-1:0]   memWdata,
  output logic                memWe,
  output logic                halted
);

  ctlT  ctl;
  logic accZero;

  accum_core_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .memRdata (memRdata),
    .accZero  (accZero),
    .ctl      (ctl),
    .halted   (halted)
  );

  accum_core_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe),
    .accZero  (accZero)
  );

  // A store strobe lasts a single cycle
  assert_single_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  // While stopped the core keeps refetching the same address
  assert_spin_in_place_R9: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> $stable(memAddr));

endmodule

// File: tb/accum_core_test.sv
`timescale 1ns/1ps
module accum_core_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] memAddr;
  logic [7:0]  memRdata = 8'h00;
  logic [7:0]  memWdata;
  logic        memWe;
  logic        halted;

  int total = 0;
  int bad = 0;
  int writeCount = 0;
  logic doubleWe = 1'b0;
  logic prevWe = 1'b0;
  logic [15:0] lastWAddr = '0;

  logic [7:0] mem [0:4095];

  always #2.5 clk = ~clk;

  accum_core uut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRdata(memRdata),
    .memWdata(memWdata), .memWe(memWe), .halted(halted)
  );

  function automatic int ix(input logic [15:0] a);
    return int'(a[11:0]);
  endfunction

  // Memory model: one-clock read latency
  always @(posedge clk) begin
    if (memWe) mem[ix(memAddr)] <= memWdata;
    memRdata <= mem[ix(memAddr)];
  end

  // Write monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (memWe) begin
        writeCount++;
        lastWAddr = memAddr;
        if (prevWe) doubleWe = 1'b1;
      end
      prevWe = memWe;
    end else begin
      prevWe = 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] v);
    mem[ix(a)] = v;
  endtask

  task automatic putIns(input logic [15:0] a, input logic [7:0] op, input logic [15:0] t);
    put(a, op);
    put(a + 16'd1, t[15:8]);
    put(a + 16'd2, t[7:0]);
  endtask

  task automatic beginTest();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    writeCount = 0;
    doubleWe = 1'b0;
  endtask

  task automatic runToHalt(output int edges);
    rstN = 1'b1;
    edges = 0;
    while (!halted && edges < 400) begin
      @(negedge clk);
      edges++;
    end
  endtask

  task automatic testStopAtZero();
    int e;
    logic [15:0] a;
    beginTest();
    runToHalt(e);
    check("R9 halt latency", e, 2);
    a = memAddr;
    check("R9 spin address", a, 16'h0000);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R9 spin stable", {memAddr, 15'd0, halted}, {a, 15'd0, 1'b1});
    end
    check("R9 no writes", writeCount, 0);
  endtask

  task automatic testReset();
    beginTest();
    check("R1 reset address", memAddr, 16'h0000);
    check("R1 reset strobe", memWe, 0);
    check("R1 reset halted", halted, 0);
  endtask

  task automatic testLoadAddStore();
    int e;
    beginTest();
    putIns(16'h0000, 8'h01, 16'h0A10);
    putIns(16'h0003, 8'h04, 16'h0A11);
    putIns(16'h0006, 8'h02, 16'h0123);
    put(16'h0A10, 8'd20);
    put(16'h0A11, 8'd30);
    runToHalt(e);
    check("R2 R4 load add result", mem[ix(16'h0123)], 8'd50);
    check("R3 big-endian target untouched", mem[ix(16'h2301)], 8'h00);
    check("R11 nine clocks per instruction", e, 29);
    check("R6 one write", writeCount, 1);
    check("R6 write one cycle", doubleWe, 0);
    check("R6 write address", lastWAddr, 16'h0123);
  endtask

  task automatic testAddWrap();
    int e;
    beginTest();
    putIns(16'h0000, 8'h01, 16'h0A20);
    putIns(16'h0003, 8'h04, 16'h0A21);
    putIns(16'h0006, 8'h02, 16'h0A30);
    put(16'h0A20, 8'hFF);
    put(16'h0A21, 8'h01);
    put(16'h0A30, 8'hAA);
    runToHalt(e);
    check("R4 add wrap", mem[ix(16'h0A30)], 8'h00);
  endtask

  task automatic testSubWrap();
    int e;
    beginTest();
    putIns(16'h0000, 8'h08, 16'h0A40);
    putIns(16'h0003, 8'h02, 16'h0A41);
    put(16'h0A40, 8'h01);
    runToHalt(e);
    check("R5 sub wrap", mem[ix(16'h0A41)], 8'hFF);
    check("R1 accumulator starts at zero", e, 20);
  endtask

  task automatic testJump();
    int e;
    beginTest();
    putIns(16'h0000, 8'h10, 16'h0800);
    putIns(16'h0003, 8'h02, 16'h0A60);
    putIns(16'h0800, 8'h01, 16'h0A50);
    putIns(16'h0803, 8'h02, 16'h0A61);
    put(16'h0A50, 8'h5C);
    put(16'h0A60, 8'h77);
    runToHalt(e);
    check("R7 jump target ran", mem[ix(16'h0A61)], 8'h5C);
    check("R7 fall-through skipped", mem[ix(16'h0A60)], 8'h77);
    check("R7 stop address", memAddr, 16'h0806);
  endtask

  task automatic testJzTaken();
    int e;
    beginTest();
    putIns(16'h0000, 8'h20, 16'h0900);
    putIns(16'h0003, 8'h02, 16'h0A70);
    putIns(16'h0900, 8'h01, 16'h0A71);
    putIns(16'h0903, 8'h02, 16'h0A72);
    put(16'h0A70, 8'h33);
    put(16'h0A71, 8'h42);
    runToHalt(e);
    check("R8 taken target ran", mem[ix(16'h0A72)], 8'h42);
    check("R8 taken skipped next", mem[ix(16'h0A70)], 8'h33);
  endtask

  task automatic testJzNotTaken();
    int e;
    beginTest();
    putIns(16'h0000, 8'h01, 16'h0A80);
    putIns(16'h0003, 8'h20, 16'h0900);
    putIns(16'h0006, 8'h02, 16'h0A81);
    put(16'h0A80, 8'h01);
    runToHalt(e);
    check("R8 not taken store", mem[ix(16'h0A81)], 8'h01);
    check("R8 not taken stop address", memAddr, 16'h0009);
  endtask

  task automatic testUndefined();
    logic [7:0] codes [4] = '{8'h03, 8'h0C, 8'h40, 8'h80};
    for (int k = 0; k < 4; k++) begin
      int e;
      beginTest();
      putIns(16'h0000, codes[k], 16'h0A90);
      runToHalt(e);
      check("R10 undefined halts", e, 2);
      repeat (3) @(negedge clk);
      check("R10 undefined spins", memAddr, 16'h0000);
      check("R10 undefined no write", writeCount, 0);
    end
  endtask

  task automatic testWrap();
    int e;
    beginTest();
    putIns(16'h0000, 8'h20, 16'hFFFA);
    putIns(16'hFFFA, 8'h01, 16'h0A90);
    putIns(16'hFFFD, 8'h02, 16'h0A91);
    put(16'h0A90, 8'h9E);
    runToHalt(e);
    check("R12 wrapped program stored", mem[ix(16'h0A91)], 8'h9E);
    check("R12 fetch wrapped to zero", memAddr, 16'h0003);
    check("R12 clock count", e, 38);
  endtask

  initial begin
    testStopAtZero();
    testReset();
    testLoadAddStore();
    testAddWrap();
    testSubWrap();
    testJump();
    testJzTaken();
    testJzNotTaken();
    testUndefined();
    testWrap();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R11 watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule